// File: doc/BRIEF.md
# Straddled Completion Beat Rule Monitor

This block is a passive observer on a 512-bit completion beat interface that can carry two packets in the same beat ("straddling"). It never drives the bus. On each beat the receiver accepts (valid and ready both high), it reads the two start flags, the start offset of the second packet, the two end flags and the two end-Dword offsets. It checks them against the placement rules for a straddled beat.

The block also tracks whether a packet is still in flight across beats. This lets it catch a start that lands on an unfinished packet, and an end that has no packet to close. Every violation sets its own bit in a registered error code, which is visible for exactly one cycle after the offending beat. Any violation also sets a sticky error flag, which holds until reset. Several bits can rise together when one beat breaks several rules.

A second packet in a beat always begins at Dword 8 (byte 32). It can therefore only end at Dword 10 to 15 (byte lanes 43 to 63), and the first packet must have ended below Dword 8.

Top module: `strd_rule_mon`

## Requirements
- R1: An accepted beat with the second start flag (`sop_flag[1]`) set and the first end flag (`eop_flag[0]`) clear sets error bit 0.
- R2: An accepted beat with `sop_flag[1]` set and `sop1_off` not equal to 2'b10 sets error bit 1.
- R3: An accepted beat with the second end flag (`eop_flag[1]`) set, but without both `eop_flag[0]` and `sop_flag[0]`, sets error bit 2.
- R4: An accepted beat with `eop_flag[1]` set and `eop1_off` below 10 sets error bit 3. Values 10 to 15 are legal.
- R5: An accepted beat with `sop_flag[0]` set while a packet is open and `eop_flag[0]` clear sets error bit 4.
- R6: An accepted beat carrying more end flags than the number of packets available to close sets error bit 5. The packets available are the open packet plus the start flags in that beat. A lone end with nothing open is the basic case.
- R7: `pkt_open` reports the in-flight state one cycle after each accepted beat. It is high exactly when the open packet plus the start flags in the beat outnumber the end flags.
- R8: A beat counts only when `beat_vld` and `beat_rdy` are both high. Any other cycle leaves `pkt_open`, `err_code` (zero) and `err_sticky` unchanged.
- R9: `err_code` is registered. It shows the violations of an accepted beat in the following cycle only, with one bit per rule, so that several bits can be set together. It returns to zero after that cycle.
- R10: `err_sticky` rises with the first nonzero `err_code` and holds until reset. Reset clears `err_code`, `err_sticky` and `pkt_open`.
- R11: An accepted beat with `sop_flag[1]` and `eop_flag[0]` set and `eop0_off` at 8 or above sets error bit 6. The first packet must end below Dword 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_vld | input | 1 | Beat valid |
| beat_rdy | input | 1 | Beat ready |
| sop_flag | input | 2 | Start flags: bit 0 first packet at Dword 0, bit 1 second packet |
| sop1_off | input | 2 | Start offset of the second packet (2'b10 = Dword 8) |
| eop_flag | input | 2 | End flags: bit 0 at least one end, bit 1 two ends |
| eop0_off | input | 4 | Last Dword of the first ending packet |
| eop1_off | input | 4 | Last Dword of the second ending packet |
| err_code | output | 7 | One-cycle error vector, one bit per rule |
| err_sticky | output | 1 | Sticky error flag |
| pkt_open | output | 1 | A packet is in flight across beats |

## Verification
A flag rule and an in-flight-state rule can be broken by the same beat. The sharpest case is a lone second start with a bad offset: it breaks two flag rules and also opens a packet. The bench drives such beats and expects the exact multi-bit code in the cycle after the beat. It then expects that code to clear on the next idle cycle and `pkt_open` to show the state the beat produced. Legal straddled beats at the pointer limits (end offsets 7 and 10, 15) are driven alongside, and they must leave the code at zero.

// File: rtl/strd_pkg.sv
`timescale 1ns/1ps
package strd_pkg;
  localparam int ERR_W      = 7;
  localparam int E_S1_NO_E0 = 0;
  localparam int E_S1_OFF   = 1;
  localparam int E_E1_DEP   = 2;
  localparam int E_E1_OFF   = 3;
  localparam int E_OVERLAP  = 4;
  localparam int E_ORPHAN   = 5;
  localparam int E_E0_LATE  = 6;
  typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/strd_flag_rules.sv
`timescale 1ns/1ps
module strd_flag_rules
  import strd_pkg::*;
#(
  parameter int SOP_PTR_W = 2,
  parameter int EOP_PTR_W = 4,
  parameter int SOP1_OFF  = 2,
  parameter int EOP1_MIN  = 10
) (
  input  logic [1:0]           sop,
  input  logic [SOP_PTR_W-1:0] sop1_off,
  input  logic [1:0]           eop,
  input  logic [EOP_PTR_W-1:0] eop0_off,
  input  logic [EOP_PTR_W-1:0] eop1_off,
  output err_vec_t             rule_err
);
  // Dword index where the second packet lands: offset counts 4-Dword units
  localparam int SECOND_DW = SOP1_OFF * 4;
  localparam logic [SOP_PTR_W-1:0] S1_OK  = SOP_PTR_W'(SOP1_OFF);
  localparam logic [EOP_PTR_W-1:0] E1_LO  = EOP_PTR_W'(EOP1_MIN);
  localparam logic [EOP_PTR_W-1:0] E0_LIM = EOP_PTR_W'(SECOND_DW);

  always_comb begin
    rule_err             = '0;
    rule_err[E_S1_NO_E0] = sop[1] & ~eop[0];
    rule_err[E_S1_OFF]   = sop[1] & (sop1_off != S1_OK);
    rule_err[E_E1_DEP]   = eop[1] & ~(eop[0] & sop[0]);
    rule_err[E_E1_OFF]   = eop[1] & (eop1_off < E1_LO);
    rule_err[E_E0_LATE]  = sop[1] & eop[0] & (eop0_off >= E0_LIM);
  end
endmodule

// File: rtl/strd_open_track.sv
`timescale 1ns/1ps
module strd_open_track
  import strd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  logic [1:0] sop,
  input  logic [1:0] eop,
  output logic     pkt_open,
  output err_vec_t trk_err
);
  logic       open_q, open_d;
  logic [1:0] avail_cnt, end_cnt;

  always_comb begin
    avail_cnt           = {1'b0, open_q} + {1'b0, sop[0]} + {1'b0, sop[1]};
    end_cnt             = {1'b0, eop[0]} + {1'b0, eop[1]};
    open_d              = (avail_cnt > end_cnt);
    trk_err             = '0;
    trk_err[E_OVERLAP]  = open_q & sop[0] & ~eop[0];
    trk_err[E_ORPHAN]   = (end_cnt > avail_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    open_q <= 1'b0;
    else if (fire) open_q <= open_d;
  end

  assign pkt_open = open_q;

  AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pkt_open)); // R8
  AST_LONE_SOP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sop == 2'b01 && eop == 2'b00) |=> pkt_open); // R7
endmodule

// File: rtl/strd_err_report.sv
`timescale 1ns/1ps
module strd_err_report
  import strd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  err_vec_t rule_err,
  input  err_vec_t trk_err,
  output err_vec_t err_code,
  output logic     err_sticky
);
  err_vec_t code_d, code_q;
  logic     sticky_d, sticky_q;

  always_comb begin
    code_d   = fire ? (rule_err | trk_err) : '0;
    sticky_d = sticky_q | (|code_d);
  end

  for (genvar i = 0; i < ERR_W; i++) begin : g_code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[i] <= 1'b0;
      else        code_q[i] <= code_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign err_code   = code_q;
  assign err_sticky = sticky_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R10
  AST_CODE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_code) |-> err_sticky); // R10
  AST_CODE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_code) |-> $past(fire)); // R9
endmodule

// File: rtl/strd_rule_mon.sv
`timescale 1ns/1ps
module strd_rule_mon
  import strd_pkg::*;
#(
  parameter int SOP_PTR_W = 2,
  parameter int EOP_PTR_W = 4,
  parameter int SOP1_OFF  = 2,
  parameter int EOP1_MIN  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat_vld,
  input  logic                 beat_rdy,
  input  logic [1:0]           sop_flag,
  input  logic [SOP_PTR_W-1:0] sop1_off,
  input  logic [1:0]           eop_flag,
  input  logic [EOP_PTR_W-1:0] eop0_off,
  input  logic [EOP_PTR_W-1:0] eop1_off,
  output logic [ERR_W-1:0]     err_code,
  output logic                 err_sticky,
  output logic                 pkt_open
);
  logic     rst_meta_q, rst_sync_q;
  logic     fire;
  err_vec_t rule_err, trk_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign fire = beat_vld & beat_rdy;

  strd_flag_rules #(
    .SOP_PTR_W(SOP_PTR_W), .EOP_PTR_W(EOP_PTR_W),
    .SOP1_OFF(SOP1_OFF),   .EOP1_MIN(EOP1_MIN)
  ) u_rules (
    .sop(sop_flag), .sop1_off(sop1_off), .eop(eop_flag),
    .eop0_off(eop0_off), .eop1_off(eop1_off), .rule_err(rule_err)
  );

  strd_open_track u_track (
    .clk(clk), .rst_n(rst_sync_q), .fire(fire),
    .sop(sop_flag), .eop(eop_flag),
    .pkt_open(pkt_open), .trk_err(trk_err)
  );

  strd_err_report u_report (
    .clk(clk), .rst_n(rst_sync_q), .fire(fire),
    .rule_err(rule_err), .trk_err(trk_err),
    .err_code(err_code), .err_sticky(err_sticky)
  );

  AST_BAD_S1_OFF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (fire && sop_flag[1] && sop1_off != 2'b10) |=> err_code[E_S1_OFF]); // R2
  AST_E1_LOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (fire && eop_flag[1] && eop1_off < 4'd10) |=> err_code[E_E1_OFF]); // R4
endmodule

// File: tb/sim_strd_rule_mon.sv
`timescale 1ns/1ps
module sim_strd_rule_mon;
  localparam time HALF = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       beat_vld, beat_rdy;
  logic [1:0] sop_flag, sop1_off, eop_flag;
  logic [3:0] eop0_off, eop1_off;
  logic [6:0] err_code;
  logic       err_sticky, pkt_open;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #HALF clk = ~clk;

  strd_rule_mon u0 (
    .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_rdy(beat_rdy),
    .sop_flag(sop_flag), .sop1_off(sop1_off), .eop_flag(eop_flag),
    .eop0_off(eop0_off), .eop1_off(eop1_off),
    .err_code(err_code), .err_sticky(err_sticky), .pkt_open(pkt_open)
  );

  task automatic idle_inputs();
    beat_vld = 0; beat_rdy = 0; sop_flag = 0; sop1_off = 0;
    eop_flag = 0; eop0_off = 0; eop1_off = 0;
  endtask

  task automatic chk(string req, logic [6:0] ec, logic eo, logic es);
    n_chk++;
    if (err_code !== ec || pkt_open !== eo || err_sticky !== es) begin
      n_bad++;
      $display("FAIL %s: code=%b open=%b sticky=%b expected code=%b open=%b sticky=%b",
               req, err_code, pkt_open, err_sticky, ec, eo, es);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // drive one beat at a falling edge; results are sampled at the next falling edge
  task automatic beat(logic v, logic r, logic [1:0] s, logic [1:0] sp,
                      logic [1:0] e, logic [3:0] p0, logic [3:0] p1);
    beat_vld = v; beat_rdy = r; sop_flag = s; sop1_off = sp;
    eop_flag = e; eop0_off = p0; eop1_off = p1;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 reset state", 7'b0, 0, 0);
  endtask

  task automatic t_legal();
    do_reset();
    beat(1, 1, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R7 lone start opens", 7'b0, 1, 0);
    beat(1, 1, 2'b00, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R7 mid-packet beat", 7'b0, 1, 0);
    beat(1, 1, 2'b10, 2'd2, 2'b01, 4'd5, 4'd0);
    chk("R1 R11 end then straddled start", 7'b0, 1, 0);
    beat(1, 1, 2'b00, 2'd0, 2'b01, 4'd7, 4'd0);
    chk("R11 end at Dword 7 closes", 7'b0, 0, 0);
    beat(1, 1, 2'b11, 2'd2, 2'b11, 4'd4, 4'd10);
    chk("R3 R4 two packets, second ends at 10", 7'b0, 0, 0);
    beat(1, 1, 2'b11, 2'd2, 2'b11, 4'd6, 4'd15);
    chk("R4 second end at 15", 7'b0, 0, 0);
  endtask

  task automatic t_sop1();
    do_reset();
    beat(1, 1, 2'b11, 2'd2, 2'b00, 4'd0, 4'd0);
    chk("R1 second start without first end", 7'b0000001, 1, 1);
    do_reset();
    beat(1, 1, 2'b11, 2'd1, 2'b01, 4'd3, 4'd0);
    chk("R2 second start offset 01", 7'b0000010, 1, 1);
    do_reset();
    beat(1, 1, 2'b11, 2'd3, 2'b01, 4'd3, 4'd0);
    chk("R2 second start offset 11", 7'b0000010, 1, 1);
  endtask

  task automatic t_eop1();
    do_reset();
    beat(1, 1, 2'b01, 2'd0, 2'b10, 4'd0, 4'd12);
    chk("R3 second end without first end", 7'b0000100, 0, 1);
    do_reset();
    beat(1, 1, 2'b11, 2'd2, 2'b11, 4'd3, 4'd9);
    chk("R4 second end at 9", 7'b0001000, 0, 1);
    do_reset();
    beat(1, 1, 2'b11, 2'd2, 2'b11, 4'd3, 4'd0);
    chk("R4 second end at 0", 7'b0001000, 0, 1);
  endtask

  task automatic t_open();
    do_reset();
    beat(1, 1, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    beat(1, 1, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R5 start onto open packet", 7'b0010000, 1, 1);
    do_reset();
    beat(1, 1, 2'b00, 2'd0, 2'b01, 4'd2, 4'd0);
    chk("R6 end with nothing open", 7'b0100000, 0, 1);
  endtask

  task automatic t_e0late();
    do_reset();
    beat(1, 1, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    beat(1, 1, 2'b10, 2'd2, 2'b01, 4'd8, 4'd0);
    chk("R11 first end at Dword 8 with second start", 7'b1000000, 1, 1);
  endtask

  task automatic t_gate();
    do_reset();
    beat(1, 0, 2'b00, 2'd0, 2'b01, 4'd2, 4'd0);
    chk("R8 end while not ready ignored", 7'b0, 0, 0);
    beat(0, 1, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R8 start while not valid ignored", 7'b0, 0, 0);
    beat(1, 1, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R8 accepted start counts", 7'b0, 1, 0);
    beat(1, 0, 2'b01, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R8 overlap while not ready ignored", 7'b0, 1, 0);
  endtask

  task automatic t_multi();
    do_reset();
    beat(1, 1, 2'b10, 2'd0, 2'b00, 4'd0, 4'd0);
    chk("R9 two violations in one beat", 7'b0000011, 1, 1);
    @(negedge clk);
    chk("R9 code clears after one cycle", 7'b0, 1, 1);
    repeat (4) @(negedge clk);
    chk("R10 sticky holds", 7'b0, 1, 1);
    do_reset();
    chk("R10 reset clears sticky and open", 7'b0, 0, 0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    t_reset();
    t_legal();
    t_sop1();
    t_eop1();
    t_open();
    t_e0late();
    t_gate();
    t_multi();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule